// File: doc/BRIEF.md
# Control Cell Capture Buffer

This block sits behind one receive port and keeps selected control cells for a host that handles them at its own pace. Cells arrive as a byte stream. The last beat of each cell carries two qualifiers: a good flag and a change-indication value. A mode input selects the capture policy. In start-up mode the block captures every good cell. In normal mode it captures only good cells whose change-indication value differs from the value of the last captured cell. Four instances serve four ports.

The store holds four cell slots of `SLOT_BYTES` bytes each. One slot is the reference cell, which is the cell the host processed last. Up to two slots hold pending cells. The last slot takes the cell that is arriving. The host sees a two-cell window through a byte address. Address bit 6 set to 0 selects the reference cell and set to 1 selects the oldest pending cell. Bits 5:0 select the byte. The host also reads a pending-cell level and issues an advance command. Once two cells are pending, a further capture replaces the newer pending cell and sets a sticky overflow flag. The host clears that flag with a level-read strobe.

The stream input has no back-pressure. `in_ready` goes high on the first clock after reset is released and stays high. A beat is taken on every cycle where `in_valid` and `in_ready` are both high. A cell ends on the beat with `in_last` set.

Top module: `ctl_cell_capture`

## Requirements
- R1: While reset is applied, `level` reads 0 and `ovf` reads 0. `in_ready` is 0 during reset and is 1 from the first clock after reset is released.
- R2: In start-up mode (`mode_all`=1), every cell whose last beat has `in_good`=1 is captured and raises `level` by one. A cell with `in_good`=0 leaves `level` and the window unchanged.
- R3: In normal mode (`mode_all`=0), a good cell is captured only if its `in_chg` differs from the `in_chg` of the last captured cell. That stored value is 0 after reset and is updated on every capture in either mode.
- R4: `level` counts pending cells and never exceeds 2. A capture at level 2 keeps the level at 2 and replaces the newer pending cell, so the newest slot always holds the latest match.
- R5: `rd_data` returns, one clock after `rd_addr` is sampled, the byte at offset `rd_addr[5:0]` of the reference cell when `rd_addr[6]`=0, or of the oldest pending cell when `rd_addr[6]`=1. Byte k of a cell (counted from 0) is stored at offset k.
- R6: An `adv` pulse at a nonzero level makes the oldest pending cell the new reference cell and lowers `level` by one. At level 0, `adv` has no effect.
- R7: The reference cell is never overwritten by incoming cells, whether they are captured or rejected, in particular while `level` is 0.
- R8: `ovf` is set by a capture at level 2 and stays set until a `lvl_rd` pulse clears it. If a capture at level 2 and `lvl_rd` occur in the same cycle, `ovf` ends up set.
- R9: If `adv` and a capture fall in the same cycle, the advance is applied first and the capture second. A capture at level 2 together with `adv` therefore leaves level 2 and does not set `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_all | input | 1 | 1: capture every good cell; 0: capture good cells with a changed indication |
| in_valid | input | 1 | Cell byte beat valid |
| in_ready | output | 1 | Beat accepted; high from the first clock after reset |
| in_data | input | DATA_W | Cell byte |
| in_last | input | 1 | Last beat of the cell; qualifiers are sampled here |
| in_good | input | 1 | Cell passed upstream validation |
| in_chg | input | CHG_W | Change-indication value of the cell |
| adv | input | 1 | Advance the window by one cell |
| lvl_rd | input | 1 | Host level-read strobe; clears `ovf` |
| rd_addr | input | OFF_W+1 | Window byte address (bit OFF_W picks the cell) |
| rd_data | output | DATA_W | Window byte, registered |
| level | output | 2 | Pending cell count, 0 to 2 |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The slot-order table is the internal state that matters. If it is wrong, the host sees the wrong cell's bytes at the window on the first read after the next advance or the next capture at level 2. This shows up as a whole-cell mismatch, not a single bad byte. A wrong level count shows on `level` one clock after the capture or advance that caused it. It also shows later, either as an advance that fails to move the window or as a cell silently replaced too early. A wrong stored change value shows as a normal-mode cell that is captured or rejected against the rule, which appears as a level step the bench does not expect.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int NSLOT    = 4;
  localparam int SLOT_W   = 2;
  localparam int LVL_W    = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [LVL_W-1:0]  lvl_t;
  localparam lvl_t LVL_FULL = 2'd2;
endpackage

// File: rtl/ccc_capture_filter.sv
module ccc_capture_filter
  import ccc_pkg::*;
#(
  parameter int CHG_W      = 8,
  parameter int SLOT_BYTES = 64,
  localparam int OFF_W     = $clog2(SLOT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_all,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_good,
  input  logic [CHG_W-1:0] in_chg,
  output logic             in_ready,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_off,
  output logic             commit
);
  logic             rdy_q;
  logic [OFF_W-1:0] off_q;
  logic [CHG_W-1:0] last_chg_q;
  logic             beat;
  logic             qualify;

  assign in_ready = rdy_q;
  assign beat     = in_valid & rdy_q;
  assign qualify  = in_good & (mode_all | (in_chg != last_chg_q));
  assign commit   = beat & in_last & qualify;
  assign wr_en    = beat;
  assign wr_off   = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      off_q      <= '0;
      last_chg_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (beat) off_q <= in_last ? '0 : off_q + 1'b1;
      if (commit) last_chg_q <= in_chg;
    end
  end
endmodule

// File: rtl/ccc_slot_mgr.sv
module ccc_slot_mgr
  import ccc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  commit,
  input  logic  lvl_rd,
  output lvl_t  level,
  output logic  ovf,
  output slot_t ref_slot,
  output slot_t nxt_slot,
  output slot_t fill_slot
);
  slot_t [NSLOT-1:0] ord_q, ord_a, ord_n;
  lvl_t              lvl_q, lvl_a, lvl_n;
  logic              ovf_q, ovf_n;
  logic [SLOT_W-1:0] fill_pos;

  // Step 1: advance (rotate order, drop level); step 2: capture.
  always_comb begin
    ord_a = ord_q;
    lvl_a = lvl_q;
    if (adv && lvl_q != '0) begin
      for (int i = 0; i < NSLOT; i++) ord_a[i] = ord_q[(i + 1) % NSLOT];
      lvl_a = lvl_q - 1'b1;
    end
    ord_n = ord_a;
    lvl_n = lvl_a;
    ovf_n = ovf_q & ~lvl_rd;
    if (commit) begin
      if (lvl_a == LVL_FULL) begin
        ord_n[LVL_FULL] = ord_a[NSLOT-1];
        ord_n[NSLOT-1]  = ord_a[LVL_FULL];
        ovf_n           = 1'b1;
      end else begin
        lvl_n = lvl_a + 1'b1;
      end
    end
  end

  // The slot that receives bytes keeps its identity across an advance.
  assign fill_pos  = (lvl_q == LVL_FULL) ? SLOT_W'(NSLOT - 1) : lvl_q + 1'b1;
  assign fill_slot = ord_q[fill_pos];
  assign ref_slot  = ord_q[0];
  assign nxt_slot  = ord_q[1];
  assign level     = lvl_q;
  assign ovf       = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) ord_q[i] <= slot_t'(i);
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ord_q <= ord_n;
      lvl_q <= lvl_n;
      ovf_q <= ovf_n;
    end
  end
endmodule

// File: rtl/ccc_store.sv
module ccc_store
  import ccc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 64,
  localparam int OFF_W     = $clog2(SLOT_BYTES),
  localparam int DEPTH     = NSLOT * SLOT_BYTES
) (
  input  logic              clk,
  input  logic              we,
  input  slot_t             wslot,
  input  logic [OFF_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  slot_t             rslot,
  input  logic [OFF_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wslot, woff}] <= wdata;
    rdata <= mem[{rslot, roff}];
  end
endmodule

// File: rtl/ctl_cell_capture.sv
module ctl_cell_capture
  import ccc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHG_W      = 8,
  parameter int SLOT_BYTES = 64,
  localparam int OFF_W     = $clog2(SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_all,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_good,
  input  logic [CHG_W-1:0]  in_chg,
  input  logic              adv,
  input  logic              lvl_rd,
  input  logic [OFF_W:0]    rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        level,
  output logic              ovf
);
  logic             wr_en;
  logic [OFF_W-1:0] wr_off;
  logic             commit;
  slot_t            ref_slot, nxt_slot, fill_slot, rd_slot;
  lvl_t             lvl;

  ccc_capture_filter #(.CHG_W(CHG_W), .SLOT_BYTES(SLOT_BYTES)) u_filter (
    .clk(clk), .rst_n(rst_n), .mode_all(mode_all),
    .in_valid(in_valid), .in_last(in_last), .in_good(in_good), .in_chg(in_chg),
    .in_ready(in_ready), .wr_en(wr_en), .wr_off(wr_off), .commit(commit)
  );

  ccc_slot_mgr u_slots (
    .clk(clk), .rst_n(rst_n), .adv(adv), .commit(commit), .lvl_rd(lvl_rd),
    .level(lvl), .ovf(ovf), .ref_slot(ref_slot), .nxt_slot(nxt_slot),
    .fill_slot(fill_slot)
  );

  assign rd_slot = rd_addr[OFF_W] ? nxt_slot : ref_slot;
  assign level   = lvl;

  ccc_store #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES)) u_store (
    .clk(clk), .we(wr_en), .wslot(fill_slot), .woff(wr_off), .wdata(in_data),
    .rslot(rd_slot), .roff(rd_addr[OFF_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/ctl_cell_capture_chk.sv
module ctl_cell_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       adv,
  input logic       lvl_rd,
  input logic [1:0] level,
  input logic       ovf
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  p_level_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 2'd2);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !in_valid) |=> $stable(level));

  p_adv_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && level == 2'd0 && !(in_valid && in_last)) |=> level == 2'd0);

  p_adv_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && level != 2'd0 && !(in_valid && in_last)) |=> level == $past(level) - 2'd1);

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !lvl_rd) |=> ovf);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(level) == 2'd2 && $past(in_valid && in_last) && !$past(adv)));
endmodule

bind ctl_cell_capture ctl_cell_capture_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .adv(adv), .lvl_rd(lvl_rd), .level(level), .ovf(ovf)
);

// File: tb/test_ctl_cell_capture.sv
module test_ctl_cell_capture;
  localparam int CELL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_all = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_good = 1'b0;
  logic [7:0] in_chg = '0;
  logic       adv = 1'b0;
  logic       lvl_rd = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] level;
  logic       ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctl_cell_capture i_ctl_cell_capture (
    .clk(clk), .rst_n(rst_n), .mode_all(mode_all), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .in_good(in_good),
    .in_chg(in_chg), .adv(adv), .lvl_rd(lvl_rd), .rd_addr(rd_addr),
    .rd_data(rd_data), .level(level), .ovf(ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cell(input logic [7:0] tag, input bit good, input logic [7:0] chg,
                           input bit adv_last, input bit rd_last);
    for (int k = 0; k < CELL; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = tag + 8'(k);
      in_last  = (k == CELL - 1);
      in_good  = good;
      in_chg   = chg;
      adv      = adv_last && (k == CELL - 1);
      lvl_rd   = rd_last && (k == CELL - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; adv = 1'b0; lvl_rd = 1'b0;
  endtask

  task automatic do_adv();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
  endtask

  task automatic do_lvl_rd();
    @(negedge clk); lvl_rd = 1'b1;
    @(negedge clk); lvl_rd = 1'b0;
  endtask

  task automatic rd_byte(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 level in reset", 16'(level), 16'd0);
    check("R1 ovf in reset", 16'(ovf), 16'd0);
    check("R1 ready low in reset", 16'(in_ready), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 16'(in_ready), 16'd1);
    d = 8'h0;
  endtask

  task automatic t_startup_capture();
    logic [7:0] d;
    mode_all = 1'b1;
    send_cell(8'h10, 1'b1, 8'd1, 1'b0, 1'b0);
    check("R2 good cell captured", 16'(level), 16'd1);
    send_cell(8'h20, 1'b0, 8'd2, 1'b0, 1'b0);
    check("R2 bad cell ignored", 16'(level), 16'd1);
    rd_byte(7'h40, d);
    check("R5 next cell byte 0", 16'(d), 16'h10);
    do_adv();
    check("R6 advance lowers level", 16'(level), 16'd0);
    rd_byte(7'h00, d);
    check("R5 ref byte 0", 16'(d), 16'h10);
    rd_byte(7'h07, d);
    check("R5 ref byte 7", 16'(d), 16'h17);
  endtask

  task automatic t_idle_advance();
    logic [7:0] d;
    do_adv();
    check("R6 advance at level 0", 16'(level), 16'd0);
    rd_byte(7'h03, d);
    check("R6 ref unchanged after idle advance", 16'(d), 16'h13);
    send_cell(8'h30, 1'b0, 8'd9, 1'b0, 1'b0);
    check("R2 rejected cell level", 16'(level), 16'd0);
    rd_byte(7'h02, d);
    check("R7 ref kept at level 0", 16'(d), 16'h12);
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    send_cell(8'h40, 1'b1, 8'd3, 1'b0, 1'b0);
    send_cell(8'h50, 1'b1, 8'd4, 1'b0, 1'b0);
    check("R4 level two", 16'(level), 16'd2);
    check("R8 no ovf yet", 16'(ovf), 16'd0);
    rd_byte(7'h40, d);
    check("R5 oldest pending shown", 16'(d), 16'h40);
    send_cell(8'h60, 1'b1, 8'd5, 1'b0, 1'b0);
    check("R4 level saturates", 16'(level), 16'd2);
    check("R8 ovf set", 16'(ovf), 16'd1);
    rd_byte(7'h05, d);
    check("R7 ref kept when full", 16'(d), 16'h15);
    do_adv();
    check("R8 ovf sticky across advance", 16'(ovf), 16'd1);
    rd_byte(7'h00, d);
    check("R6 ref is oldest", 16'(d), 16'h40);
    rd_byte(7'h47, d);
    check("R4 newest replaced", 16'(d), 16'h67);
    do_lvl_rd();
    check("R8 ovf cleared by level read", 16'(ovf), 16'd0);
    do_adv();
    rd_byte(7'h05, d);
    check("R6 ref after second advance", 16'(d), 16'h65);
    check("R6 level back to 0", 16'(level), 16'd0);
  endtask

  task automatic t_normal_mode();
    logic [7:0] d;
    mode_all = 1'b0;
    send_cell(8'h70, 1'b1, 8'd5, 1'b0, 1'b0);
    check("R3 same chg rejected", 16'(level), 16'd0);
    send_cell(8'h80, 1'b1, 8'd6, 1'b0, 1'b0);
    check("R3 changed chg captured", 16'(level), 16'd1);
    send_cell(8'h90, 1'b1, 8'd6, 1'b0, 1'b0);
    check("R3 repeat chg rejected", 16'(level), 16'd1);
    send_cell(8'hA0, 1'b0, 8'd7, 1'b0, 1'b0);
    check("R3 bad cell rejected", 16'(level), 16'd1);
    rd_byte(7'h41, d);
    check("R3 pending is captured cell", 16'(d), 16'h81);
    do_adv();
    rd_byte(7'h06, d);
    check("R3 ref after advance", 16'(d), 16'h86);
  endtask

  task automatic t_adv_and_capture();
    logic [7:0] d;
    send_cell(8'hB0, 1'b1, 8'd8, 1'b0, 1'b0);
    send_cell(8'hC0, 1'b1, 8'd9, 1'b0, 1'b0);
    check("R9 level before", 16'(level), 16'd2);
    send_cell(8'hD0, 1'b1, 8'd10, 1'b1, 1'b0);
    check("R9 level stays two", 16'(level), 16'd2);
    check("R9 no ovf", 16'(ovf), 16'd0);
    rd_byte(7'h00, d);
    check("R9 ref advanced", 16'(d), 16'hB0);
    rd_byte(7'h40, d);
    check("R9 next kept", 16'(d), 16'hC0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    send_cell(8'hE0, 1'b1, 8'd11, 1'b0, 1'b1);
    check("R8 set wins over clear", 16'(ovf), 16'd1);
    check("R4 level at two", 16'(level), 16'd2);
    rd_byte(7'h40, d);
    check("R4 oldest pending kept", 16'(d), 16'hC0);
    do_adv();
    rd_byte(7'h44, d);
    check("R4 latest match in newest slot", 16'(d), 16'hE4);
  endtask

  initial begin
    t_reset();
    t_startup_capture();
    t_idle_advance();
    t_saturate();
    t_normal_mode();
    t_adv_and_capture();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule